// File: doc/BRIEF.md
# SAR Converter Sequencer with Parallel Port

This block is the digital sequencer of a 12-bit successive-approximation converter that sits behind a microprocessor-style parallel port. A write strobe, qualified by chip select, latches a control byte. The byte sets the power state, the clock source, the acquisition style, the input mode, the output polarity and the channel. The block steps the track/hold through acquisition. It then runs the bit-by-bit search against a one-bit comparator input and presents the trial code on `dac_code`. When the search ends, it latches the result and pulls an active-low interrupt.

All strobes are sampled on the system clock `clk`. Conversion timing comes from one of two tick inputs, each a one-cycle enable: `ext_tick` for the externally supplied conversion clock and `osc_tick` for the on-chip oscillator. Tri-state behaviour appears at the edge as output-enable pins beside each output. The analog parts, the reference and the oscillator are not part of this block.

Top module: `adc_sar_ctrl`

## Requirements
- R1: On a write rising edge with chip select low, the byte on `din` is latched and decoded as follows. Bits 7:6 are the power code. Bit 5 selects external acquisition when 1. Bit 4 selects single-ended input when 1. Bit 3 selects unipolar when 1. Bits 2:0 are the channel, shown on `mux_sel`.
- R2: Power code 00 gives full power-down (`pwr_full`) and 01 gives standby (`pwr_standby`). Code 10 runs from the internal oscillator (`int_clk_sel`=1) and code 11 runs from the external clock (`int_clk_sel`=0).
- R3: A power-down code leaves the clock source unchanged. After reset the block uses the external clock, `int_n` is high, and nothing is tracking or converting.
- R4: With bit 5 clear, `track` is high from the write through three conversion ticks. The fourth tick ends acquisition and raises `busy`.
- R5: With bit 5 set, tracking lasts until a later write with bit 5 clear. That write ends acquisition and starts the conversion at once.
- R6: A conversion spans 13 ticks. Ticks 1 to 12 settle one bit each, MSB first: the bit under trial is set in `dac_code`, and it is kept when `cmp_hi` is 1. The 13th tick latches the result and drives `int_n` low.
- R7: `int_n` returns high on a read falling edge or on any write.
- R8: A write during a conversion aborts it and starts the acquisition that the new byte asks for.
- R9: While `cs_n` is high, writes, reads and external ticks have no effect, and `int_oe` and `dout_oe` are low. `dout_oe` is high only when `cs_n` and `rd_n` are both low.
- R10: The result is straight binary when unipolar. When bipolar it is two's complement, which is the search code with its MSB inverted.
- R11: Under either power-down code no acquisition or conversion runs. The next write with a normal-operation code restarts acquisition.
- R12: If the second write of an external acquisition carries bits 4:0 that differ from the first, `addr_err` goes high and the conversion still completes. Any other write clears `addr_err`.
- R13: With the internal oscillator selected, only `osc_tick` advances the sequencer and `ext_tick` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; its rising edge latches `din` |
| rd_n | input | 1 | Read strobe, active low |
| din | input | 8 | Control byte |
| ext_tick | input | 1 | One-cycle pulse per external conversion clock edge |
| osc_tick | input | 1 | One-cycle pulse per internal oscillator edge |
| cmp_hi | input | 1 | Comparator decision: input at or above `dac_code` |
| dout | output | 12 | Result latch |
| dout_oe | output | 1 | Enable for the result bus driver |
| int_n | output | 1 | End-of-conversion interrupt, active low |
| int_oe | output | 1 | Enable for the interrupt driver |
| dac_code | output | 12 | Trial code for the capacitive DAC |
| track | output | 1 | Track/hold in tracking |
| busy | output | 1 | Conversion in progress |
| mux_sel | output | 3 | Selected channel |
| single_ended | output | 1 | Single-ended input mode |
| unipolar | output | 1 | Unipolar output coding |
| pwr_full | output | 1 | Full power-down selected |
| pwr_standby | output | 1 | Standby selected |
| int_clk_sel | output | 1 | Internal oscillator drives the conversion |
| addr_err | output | 1 | Setting changed between external-acquisition writes |

## Verification
The bench models the analog input as a 12-bit level. It answers the comparator by comparing that level with `dac_code`, so every conversion checks the search order and the coding together. Directed levels with sparse and dense bit patterns, plus random levels and channels under both polarities, separate a wrong bit order, a dropped bit and a wrong MSB inversion. Tick counts exactly one short of each boundary show whether an acquisition or conversion ends a tick early or late. Aborts, power-down writes and strobes with chip select high show whether the sequencer reacts to input it must not act on.

// File: rtl/adc_sar_pkg.sv
`timescale 1ns/1ps
// Shared types for the SAR sequencer: the decoded control byte and the
// sequencer state. The struct field order matches the bit order of the byte.
package adc_sar_pkg;
    typedef struct packed {
        logic [1:0] pd;
        logic       acq_ext;
        logic       single;
        logic       unipolar;
        logic [2:0] chan;
    } ctl_byte_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQ_INT,
        ST_ACQ_EXT,
        ST_CONV
    } seq_state_t;

    localparam logic [1:0] PD_FULL = 2'b00;
    localparam logic [1:0] PD_STBY = 2'b01;
    localparam logic [1:0] PD_NINT = 2'b10;
    localparam logic [1:0] PD_NEXT = 2'b11;
endpackage

// File: rtl/adc_strobe_edge.sv
`timescale 1ns/1ps
// Edge detection for the port strobes. It produces a write-rise and a
// read-fall pulse, both qualified by chip select.
// Assumes the strobes are already synchronous to clk.
module adc_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic wr_rise,
    output logic rd_fall
);
    logic wr_q;
    logic rd_q;

    // keep last sampled strobe levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= wr_n;
            rd_q <= rd_n;
        end
    end

    assign wr_rise = !cs_n && !wr_q && wr_n;
    assign rd_fall = !cs_n && rd_q && !rd_n;
endmodule

// File: rtl/adc_ctl_reg.sv
`timescale 1ns/1ps
// Control byte latch and decode. The power-down codes leave the clock
// source alone. Reset selects normal operation on the external clock.
module adc_ctl_reg
    import adc_sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_rise,
    input  ctl_byte_t  wbyte,
    output logic [1:0] pd,
    output logic       single,
    output logic       unipolar,
    output logic [2:0] chan,
    output logic       clk_int
);
    // latch settings on each accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd       <= PD_NEXT;
            single   <= 1'b0;
            unipolar <= 1'b0;
            chan     <= '0;
        end else if (wr_rise) begin
            pd       <= wbyte.pd;
            single   <= wbyte.single;
            unipolar <= wbyte.unipolar;
            chan     <= wbyte.chan;
        end
    end

    // clock source follows only the normal-operation codes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_int <= 1'b0;
        end else if (wr_rise && (wbyte.pd == PD_NINT || wbyte.pd == PD_NEXT)) begin
            clk_int <= (wbyte.pd == PD_NINT);
        end
    end
endmodule

// File: rtl/adc_sar_seq.sv
`timescale 1ns/1ps
// Acquisition timer and successive-approximation search. A write picks
// the acquisition style or aborts. Conversion ticks step the search MSB
// first and the last tick issues a one-cycle done pulse.
// Assumes tick is a single-cycle enable from the selected clock source.
module adc_sar_seq
    import adc_sar_pkg::*;
#(
    parameter int RES       = 12,
    parameter int ACQ_TICKS = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_rise,
    input  ctl_byte_t      wbyte,
    input  logic           tick,
    input  logic           cmp_hi,
    output logic           track,
    output logic           busy,
    output logic           done,
    output logic [RES-1:0] sar_val,
    output logic [RES-1:0] dac_code,
    output logic           addr_err
);
    localparam int CONV_TICKS = RES + 1;
    localparam int CNT_MAX    = (CONV_TICKS > ACQ_TICKS + 1) ? CONV_TICKS : ACQ_TICKS + 1;
    localparam int CW         = $clog2(CNT_MAX + 1);
    localparam logic [RES-1:0] MSB_ONLY = {1'b1, {(RES-1){1'b0}}};

    seq_state_t     state;
    logic [CW-1:0]  cnt;
    logic [RES-1:0] sar;
    logic [RES-1:0] mask;
    logic [4:0]     ref_bits;
    logic [4:0]     new_bits;

    assign new_bits = {wbyte.single, wbyte.unipolar, wbyte.chan};

    // sequencer state, counters and search register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sar      <= '0;
            mask     <= '0;
            ref_bits <= '0;
            addr_err <= 1'b0;
        end else if (wr_rise) begin
            cnt      <= '0;
            addr_err <= 1'b0;
            if (wbyte.pd == PD_FULL || wbyte.pd == PD_STBY) begin
                state <= ST_IDLE;
            end else if (wbyte.acq_ext) begin
                state    <= ST_ACQ_EXT;
                ref_bits <= new_bits;
            end else if (state == ST_ACQ_EXT) begin
                state    <= ST_CONV;
                sar      <= '0;
                mask     <= MSB_ONLY;
                addr_err <= (new_bits != ref_bits);
            end else begin
                state <= ST_ACQ_INT;
            end
        end else if (tick) begin
            case (state)
                ST_ACQ_INT: begin
                    if (cnt == CW'(ACQ_TICKS)) begin
                        state <= ST_CONV;
                        cnt   <= '0;
                        sar   <= '0;
                        mask  <= MSB_ONLY;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (cnt == CW'(CONV_TICKS - 1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        if (cmp_hi) sar <= sar | mask;
                        mask <= mask >> 1;
                        cnt  <= cnt + 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign track    = (state == ST_ACQ_INT) || (state == ST_ACQ_EXT);
    assign busy     = (state == ST_CONV);
    assign done     = !wr_rise && tick && busy && (cnt == CW'(CONV_TICKS - 1));
    assign sar_val  = sar;
    assign dac_code = sar | mask;
endmodule

// File: rtl/adc_result_port.sv
`timescale 1ns/1ps
// Result latch, output coding, interrupt flag and the driver enables.
// On the done pulse the code is latched, with its MSB flipped for
// bipolar. A write clears the flag ahead of everything else, and done
// wins over a read in the same cycle.
module adc_result_port #(
    parameter int RES = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           rd_n,
    input  logic           done,
    input  logic           wr_rise,
    input  logic           rd_fall,
    input  logic           unipolar,
    input  logic [RES-1:0] sar_val,
    output logic [RES-1:0] dout,
    output logic           dout_oe,
    output logic           int_n,
    output logic           int_oe
);
    logic [RES-1:0] res_q;
    logic           flag_q;

    // latch the coded result at the end of a conversion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (done) begin
            res_q <= unipolar ? sar_val : {~sar_val[RES-1], sar_val[RES-2:0]};
        end
    end

    // end-of-conversion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wr_rise) begin
            flag_q <= 1'b0;
        end else if (done) begin
            flag_q <= 1'b1;
        end else if (rd_fall) begin
            flag_q <= 1'b0;
        end
    end

    assign dout    = res_q;
    assign dout_oe = !cs_n && !rd_n;
    assign int_n   = !flag_q;
    assign int_oe  = !cs_n;
endmodule

// File: rtl/adc_sar_ctrl.sv
`timescale 1ns/1ps
// Top of the SAR converter sequencer with its parallel port. It picks
// the tick source from the clock-mode setting, gates the external tick
// with chip select, and joins the strobe, control, search and result
// stages together.
module adc_sar_ctrl
    import adc_sar_pkg::*;
#(
    parameter int RES       = 12,
    parameter int ACQ_TICKS = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           wr_n,
    input  logic           rd_n,
    input  logic [7:0]     din,
    input  logic           ext_tick,
    input  logic           osc_tick,
    input  logic           cmp_hi,
    output logic [RES-1:0] dout,
    output logic           dout_oe,
    output logic           int_n,
    output logic           int_oe,
    output logic [RES-1:0] dac_code,
    output logic           track,
    output logic           busy,
    output logic [2:0]     mux_sel,
    output logic           single_ended,
    output logic           unipolar,
    output logic           pwr_full,
    output logic           pwr_standby,
    output logic           int_clk_sel,
    output logic           addr_err
);
    ctl_byte_t      wbyte;
    logic           wr_rise;
    logic           rd_fall;
    logic [1:0]     pd;
    logic           clk_int;
    logic           conv_tick;
    logic           done;
    logic [RES-1:0] sar_val;

    assign wbyte = ctl_byte_t'(din);

    adc_strobe_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .wr_rise (wr_rise),
        .rd_fall (rd_fall)
    );

    adc_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_rise  (wr_rise),
        .wbyte    (wbyte),
        .pd       (pd),
        .single   (single_ended),
        .unipolar (unipolar),
        .chan     (mux_sel),
        .clk_int  (clk_int)
    );

    assign conv_tick = clk_int ? osc_tick : (ext_tick && !cs_n);

    adc_sar_seq #(
        .RES       (RES),
        .ACQ_TICKS (ACQ_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_rise  (wr_rise),
        .wbyte    (wbyte),
        .tick     (conv_tick),
        .cmp_hi   (cmp_hi),
        .track    (track),
        .busy     (busy),
        .done     (done),
        .sar_val  (sar_val),
        .dac_code (dac_code),
        .addr_err (addr_err)
    );

    adc_result_port #(
        .RES (RES)
    ) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .done     (done),
        .wr_rise  (wr_rise),
        .rd_fall  (rd_fall),
        .unipolar (unipolar),
        .sar_val  (sar_val),
        .dout     (dout),
        .dout_oe  (dout_oe),
        .int_n    (int_n),
        .int_oe   (int_oe)
    );

    assign pwr_full    = (pd == PD_FULL);
    assign pwr_standby = (pd == PD_STBY);
    assign int_clk_sel = clk_int;
endmodule

// File: rtl/adc_sar_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for adc_sar_ctrl, bound to every instance.
// It observes only the top-level ports.
module adc_sar_ctrl_chk #(
    parameter int RES = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cs_n,
    input logic           wr_n,
    input logic           int_n,
    input logic           busy,
    input logic           track,
    input logic [RES-1:0] dac_code,
    input logic [RES-1:0] dout,
    input logic           dout_oe,
    input logic           int_oe,
    input logic           pwr_full,
    input logic           pwr_standby
);
    // R7: an accepted write leaves the interrupt released
    assert_wr_clears_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(wr_n) && wr_n) |=> int_n);

    // R6: the first trial of every conversion is the MSB alone
    assert_msb_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (dac_code == {1'b1, {(RES-1){1'b0}}}));

    // R6: the interrupt only asserts as a conversion finishes
    assert_int_after_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> $past(busy));

    // R11: nothing tracks or converts under a power-down code
    assert_pd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_full || pwr_standby) |-> (!busy && !track));

    // R10: the result latch changes only at the end of a conversion
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> $past(busy));

    // R9: no output is driven while deselected
    assert_cs_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!dout_oe && !int_oe));
endmodule

bind adc_sar_ctrl adc_sar_ctrl_chk #(.RES(RES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .wr_n        (wr_n),
    .int_n       (int_n),
    .busy        (busy),
    .track       (track),
    .dac_code    (dac_code),
    .dout        (dout),
    .dout_oe     (dout_oe),
    .int_oe      (int_oe),
    .pwr_full    (pwr_full),
    .pwr_standby (pwr_standby)
);

// File: tb/adc_sar_ctrl_test.sv
`timescale 1ns/1ps
// Bench for adc_sar_ctrl: directed corner cases plus seeded random
// conversions. The comparator is answered from a modelled input level.
module adc_sar_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [7:0]  din = 8'h00;
    logic        ext_tick = 1'b0;
    logic        osc_tick = 1'b0;
    logic        cmp_hi;
    logic [11:0] dout;
    logic        dout_oe;
    logic        int_n;
    logic        int_oe;
    logic [11:0] dac_code;
    logic        track;
    logic        busy;
    logic [2:0]  mux_sel;
    logic        single_ended;
    logic        unipolar;
    logic        pwr_full;
    logic        pwr_standby;
    logic        int_clk_sel;
    logic        addr_err;

    logic [11:0] vin = 12'h000;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    assign cmp_hi = (vin >= dac_code);

    adc_sar_ctrl uut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .wr_n (wr_n), .rd_n (rd_n),
        .din (din), .ext_tick (ext_tick), .osc_tick (osc_tick), .cmp_hi (cmp_hi),
        .dout (dout), .dout_oe (dout_oe), .int_n (int_n), .int_oe (int_oe),
        .dac_code (dac_code), .track (track), .busy (busy), .mux_sel (mux_sel),
        .single_ended (single_ended), .unipolar (unipolar), .pwr_full (pwr_full),
        .pwr_standby (pwr_standby), .int_clk_sel (int_clk_sel), .addr_err (addr_err)
    );

    function automatic logic [7:0] mk(input logic [1:0] pd, input logic acq,
                                      input logic sgl, input logic uni, input logic [2:0] ch);
        return {pd, acq, sgl, uni, ch};
    endfunction

    function automatic logic [11:0] expect_code(input logic [11:0] level, input logic uni);
        return uni ? level : (level ^ 12'h800);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        cs_n = 1'b0; din = b; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic xtick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_tick = 1'b1;
            @(negedge clk); ext_tick = 1'b0;
        end
    endtask

    task automatic otick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); osc_tick = 1'b1;
            @(negedge clk); osc_tick = 1'b0;
        end
    endtask

    task automatic read_check(input string req, input logic [11:0] exp);
        @(negedge clk);
        rd_n = 1'b0;
        #1;
        check({req, " bus enabled (R9)"}, dout_oe, 1);
        check(req, dout, exp);
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        check("R7 read releases int", int_n, 1);
    endtask

    task automatic run_int(input logic [11:0] level, input logic uni, input logic [2:0] ch);
        vin = level;
        wr(mk(2'b11, 1'b0, 1'b1, uni, ch));
        xtick(17);
        check("R6 int after full conversion", int_n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd7321);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 int_oe low while deselected", int_oe, 0);
        check("R9 dout_oe low while deselected", dout_oe, 0);
        cs_n = 1'b0;
        #1;
        check("R3 reset int_n high", int_n, 1);
        check("R3 reset external clock", int_clk_sel, 0);
        check("R3 reset not busy", busy, 0);
        check("R3 reset not tracking", track, 0);

        // decode and internal acquisition timing
        vin = 12'h5A3;
        wr(mk(2'b11, 1'b0, 1'b1, 1'b1, 3'd5));
        check("R1 channel", mux_sel, 5);
        check("R1 single-ended", single_ended, 1);
        check("R1 unipolar", unipolar, 1);
        check("R2 external clock code", int_clk_sel, 0);
        check("R4 tracking after write", track, 1);
        xtick(3);
        check("R4 still tracking after 3 ticks", track, 1);
        check("R4 not busy after 3 ticks", busy, 0);
        xtick(1);
        check("R4 busy on 4th tick", busy, 1);
        check("R4 hold on 4th tick", track, 0);
        check("R6 MSB trial first", dac_code, 12'h800);
        xtick(12);
        check("R6 no int after 12 ticks", int_n, 1);
        xtick(1);
        check("R6 int on 13th tick", int_n, 0);
        check("R6 idle after conversion", busy, 0);
        read_check("R10 unipolar 5A3", 12'h5A3);

        // bipolar coding
        run_int(12'h123, 1'b0, 3'd2);
        read_check("R10 bipolar 123", 12'h923);

        // write clears int, standby
        run_int(12'h0FF, 1'b1, 3'd1);
        wr(mk(2'b01, 1'b0, 1'b1, 1'b1, 3'd1));
        check("R7 write releases int", int_n, 1);
        check("R2 standby code", pwr_standby, 1);
        check("R3 clock source kept in standby", int_clk_sel, 0);
        xtick(20);
        check("R11 no conversion in standby", busy, 0);
        check("R11 no tracking in standby", track, 0);
        vin = 12'h7FF;
        wr(mk(2'b11, 1'b0, 1'b1, 1'b1, 3'd0));
        check("R11 resumes on normal write", track, 1);
        xtick(17);
        read_check("R11 conversion after wake", 12'h7FF);

        // abort mid-conversion
        vin = 12'hABC;
        wr(mk(2'b11, 1'b0, 1'b1, 1'b1, 3'd1));
        xtick(9);
        check("R8 busy before abort", busy, 1);
        wr(mk(2'b11, 1'b0, 1'b1, 1'b1, 3'd2));
        check("R8 abort leaves conversion", busy, 0);
        check("R8 new acquisition", track, 1);
        xtick(16);
        check("R8 no int one tick early", int_n, 1);
        xtick(1);
        read_check("R8 result after abort", 12'hABC);

        // external acquisition
        vin = 12'h456;
        wr(mk(2'b11, 1'b1, 1'b1, 1'b1, 3'd3));
        check("R5 tracking on first write", track, 1);
        xtick(10);
        check("R5 still tracking", track, 1);
        check("R5 not converting", busy, 0);
        wr(mk(2'b11, 1'b0, 1'b1, 1'b1, 3'd3));
        check("R5 second write starts conversion", busy, 1);
        check("R5 hold on second write", track, 0);
        check("R12 matched settings no error", addr_err, 0);
        xtick(12);
        check("R5 no int after 12", int_n, 1);
        xtick(1);
        check("R5 int after 13", int_n, 0);
        read_check("R5 result", 12'h456);

        // mismatched second write
        vin = 12'hF0F;
        wr(mk(2'b11, 1'b1, 1'b1, 1'b1, 3'd3));
        xtick(2);
        wr(mk(2'b11, 1'b0, 1'b1, 1'b1, 3'd4));
        check("R12 mismatch flagged", addr_err, 1);
        xtick(13);
        check("R12 conversion still completes", int_n, 0);
        read_check("R12 result", 12'hF0F);

        // internal oscillator
        vin = 12'h9C4;
        wr(mk(2'b10, 1'b0, 1'b1, 1'b1, 3'd0));
        check("R2 internal clock code", int_clk_sel, 1);
        check("R12 error cleared by write", addr_err, 0);
        xtick(20);
        check("R13 ext ticks ignored", track, 1);
        check("R13 ext ticks no conversion", busy, 0);
        otick(4);
        check("R13 osc ticks drive hold", busy, 1);
        otick(13);
        check("R13 int from osc ticks", int_n, 0);
        read_check("R13 result", 12'h9C4);
        wr(mk(2'b00, 1'b0, 1'b1, 1'b1, 3'd0));
        check("R2 full power-down code", pwr_full, 1);
        check("R3 clock source kept in shutdown", int_clk_sel, 1);
        otick(10);
        check("R11 no conversion in shutdown", busy, 0);
        check("R11 no tracking in shutdown", track, 0);
        wr(mk(2'b11, 1'b0, 1'b1, 1'b1, 3'd0));
        check("R2 back to external clock", int_clk_sel, 0);
        xtick(17);
        read_check("R2 result on external clock", 12'h9C4);

        // chip select gating
        run_int(12'h321, 1'b1, 3'd0);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0;
        #1;
        check("R9 no bus drive while deselected", dout_oe, 0);
        check("R9 no int drive while deselected", int_oe, 0);
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        #1;
        check("R9 read ignored while deselected", int_n, 0);
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b0; din = mk(2'b11, 1'b0, 1'b1, 1'b1, 3'd6);
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        #1;
        check("R9 write ignored keeps int", int_n, 0);
        check("R9 write ignored no tracking", track, 0);
        check("R9 write ignored keeps channel", mux_sel, 0);
        read_check("R9 result kept", 12'h321);
        vin = 12'h2E7;
        wr(mk(2'b11, 1'b0, 1'b1, 1'b1, 3'd0));
        @(negedge clk); cs_n = 1'b1;
        xtick(10);
        @(negedge clk); cs_n = 1'b0;
        #1;
        check("R9 ticks ignored while deselected", track, 1);
        check("R9 ticks ignored no conversion", busy, 0);
        xtick(17);
        read_check("R9 result after gated ticks", 12'h2E7);

        // seeded random conversions
        for (int i = 0; i < 24; i++) begin
            logic [11:0] lv;
            logic        un;
            logic [2:0]  ch;
            lv = 12'($urandom);
            un = 1'($urandom);
            ch = 3'($urandom % 6);
            run_int(lv, un, ch);
            check("R1 random channel", mux_sel, ch);
            read_check("R10 random result", expect_code(lv, un));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule